// File: doc/BRIEF.md
# Infrared Transceiver Speed Programmer

This block switches an external infrared transceiver module between its fast and slow signalling modes without software toggling pins by hand. The module samples the level on its transmit pin at the moment its mode pin falls. The block therefore borrows both pins for a short, fixed-length handshake. It first raises the mode line with the transmit line set to the chosen speed. After a setup interval it drops the mode line and keeps the transmit level for a hold interval. It then hands both pins back to the normal transmit data and the general-purpose mode signal.

Software starts a cycle with one write to a control byte. The byte holds an enable flag, a speed flag and an active-low "programming / ready" flag. The ready flag returns to 1 by itself when the handshake ends, so software can poll it. A write that clears the enable flag while a cycle runs cancels it at once. Outside a cycle the block is transparent: both pins follow their normal sources through one output register.

Top module: `xsp_top`

## Requirements
- R1: During and right after reset, the pins read 0 and the readback `ctrl_rd` reads 3'b001 (enable 0, speed 0, ready 1).
- R2: A write to address `REG_ADDR` takes enable from data bit 7 and speed from data bit 6. `ctrl_rd` is {enable, speed, ready}. Writes to other addresses change nothing.
- R3: A write to `REG_ADDR` with bit 7 = 1 and bit 5 = 0, made while no cycle runs, starts a cycle. Ready reads 0 in the cycle after the write edge.
- R4: Setup phase: starting one clock after the write edge, `irmode_pin` is 1 and `tx_pin` equals the speed bit for `SETUP_CYC` clocks.
- R5: Hold phase: right after setup, `irmode_pin` is 0 and `tx_pin` still equals the speed bit for `HOLD_CYC` clocks.
- R6: Ready returns to 1 by itself `SETUP_CYC`+`HOLD_CYC` clocks after the write edge. From the next clock on, the pins follow their normal sources.
- R7: While a cycle drives the pins, `tx_data_in` and `gp_mode_in` have no effect on them.
- R8: Outside a cycle, `tx_pin` and `irmode_pin` show `tx_data_in` and `gp_mode_in` as sampled on the previous clock edge.
- R9: A write with bit 7 = 0 during a cycle aborts it. Ready reads 1 and enable reads 0 on the next clock, the speed bit is kept, and the pins follow their normal sources one clock later.
- R10: During a cycle, a write with bit 7 = 1 is ignored: speed, enable, ready and the pin sequence are unchanged.
- R11: A write with bit 5 = 1, or with bit 7 = 0, made while idle, stores enable and speed but starts no cycle. Ready stays 1 and the pins stay transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Write data; bit 7 enable, bit 6 speed, bit 5 not-program/ready |
| tx_data_in | input | 1 | Normal transmit data |
| gp_mode_in | input | 1 | General-purpose data used as mode pin when idle |
| tx_pin | output | 1 | Transceiver transmit pin (registered) |
| irmode_pin | output | 1 | Transceiver mode pin (registered) |
| ctrl_rd | output | 3 | Readback {enable, speed, ready} |

## Verification
The assertions assume that the write strobe, address and data are known at every edge once reset is released. They also assume that `tx_data_in` and `gp_mode_in` are never X, because the pass-through checks compare them with the pins one clock later. The stimulus keeps within this: every input is driven to a defined value before reset is released and changes only at falling clock edges. Aborting and ignored writes are timed so that they land only on edges where a cycle is actually in progress.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2
  } phase_t;

  localparam int ENA_BIT  = 7;
  localparam int SPD_BIT  = 6;
  localparam int NRDY_BIT = 5;
endpackage

// File: rtl/xsp_ctrl.sv
module xsp_ctrl
  import xsp_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              enable_q,
  output logic              speed_q,
  output logic              start,
  output logic              start_spd,
  output logic              abort
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic hit;
  assign hit       = wr_en && (wr_addr == HIT_ADDR);
  assign start     = hit && !busy && wr_data[ENA_BIT] && !wr_data[NRDY_BIT];
  assign abort     = hit && busy && !wr_data[ENA_BIT];
  assign start_spd = wr_data[SPD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      speed_q  <= 1'b0;
    end else if (hit) begin
      if (!busy) begin
        enable_q <= wr_data[ENA_BIT];
        speed_q  <= wr_data[SPD_BIT];
      end else if (!wr_data[ENA_BIT]) begin
        enable_q <= 1'b0;
      end
    end
  end

  AST_BUSY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    busy |-> enable_q); // R3

  AST_SPEED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(speed_q)); // R10
endmodule

// File: rtl/xsp_seq.sv
module xsp_seq
  import xsp_pkg::*;
#(
  parameter int SETUP_CYC = 6,
  parameter int HOLD_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_spd,
  input  logic abort,
  output logic busy,
  output logic seq_tx,
  output logic seq_mode
);
  localparam int MAX_CYC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             spd;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      spd   <= 1'b0;
    end else if (abort) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_SETUP;
            cnt   <= '0;
            spd   <= start_spd;
          end
        end
        PH_SETUP: begin
          if (cnt == SETUP_LAST) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == HOLD_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign seq_tx   = spd;
  assign seq_mode = (phase == PH_SETUP);

  AST_HOLD_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD) |-> ($past(phase) != PH_IDLE)); // R5

  AST_SPEED_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(seq_tx)); // R4

  AST_END_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (($past(phase) == PH_HOLD) || $past(abort))); // R6
endmodule

// File: rtl/xsp_pinmux.sv
module xsp_pinmux (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic seq_tx,
  input  logic seq_mode,
  input  logic tx_in,
  input  logic gp_in,
  output logic tx_pin,
  output logic irmode_pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin     <= 1'b0;
      irmode_pin <= 1'b0;
    end else if (busy) begin
      tx_pin     <= seq_tx;
      irmode_pin <= seq_mode;
    end else begin
      tx_pin     <= tx_in;
      irmode_pin <= gp_in;
    end
  end

  AST_IDLE_TX_PASS: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (tx_pin == $past(tx_in))); // R8

  AST_IDLE_MODE_PASS: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (irmode_pin == $past(gp_in))); // R8

  AST_PROG_TX_STEADY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> $stable(tx_pin)); // R7
endmodule

// File: rtl/xsp_top.sv
module xsp_top
  import xsp_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int REG_ADDR  = 0,
  parameter int SETUP_CYC = 6,
  parameter int HOLD_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tx_data_in,
  input  logic              gp_mode_in,
  output logic              tx_pin,
  output logic              irmode_pin,
  output logic [2:0]        ctrl_rd
);
  logic enable_q, speed_q, start, start_spd, abort;
  logic busy, seq_tx, seq_mode;

  xsp_ctrl #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .enable_q  (enable_q),
    .speed_q   (speed_q),
    .start     (start),
    .start_spd (start_spd),
    .abort     (abort)
  );

  xsp_seq #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_spd (start_spd),
    .abort     (abort),
    .busy      (busy),
    .seq_tx    (seq_tx),
    .seq_mode  (seq_mode)
  );

  xsp_pinmux u_pinmux (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .seq_tx     (seq_tx),
    .seq_mode   (seq_mode),
    .tx_in      (tx_data_in),
    .gp_in      (gp_mode_in),
    .tx_pin     (tx_pin),
    .irmode_pin (irmode_pin)
  );

  assign ctrl_rd = {enable_q, speed_q, ~busy};

  AST_START_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && wr_data[ENA_BIT] && !wr_data[NRDY_BIT])); // R3

  AST_ABORT_CLEARS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !enable_q)); // R9
endmodule

// File: tb/xsp_top_tb.sv
module xsp_top_tb;
  localparam int ADDR_W = 4;
  localparam int S      = 6;
  localparam int H      = 4;
  localparam int NO_AB  = 99;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              tx_data_in = 1'b0;
  logic              gp_mode_in = 1'b0;
  logic              tx_pin, irmode_pin;
  logic [2:0]        ctrl_rd;

  int checks = 0;
  int errors = 0;
  logic prev_tx = 1'b0;
  logic prev_gp = 1'b0;
  logic exp_en  = 1'b0;
  logic exp_spd = 1'b0;

  always #2 clk = ~clk;

  xsp_top #(.ADDR_W(ADDR_W), .REG_ADDR(0), .SETUP_CYC(S), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_data_in(tx_data_in), .gp_mode_in(gp_mode_in),
    .tx_pin(tx_pin), .irmode_pin(irmode_pin), .ctrl_rd(ctrl_rd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_inputs();
    tx_data_in = 1'($urandom);
    gp_mode_in = 1'($urandom);
    prev_tx = tx_data_in;
    prev_gp = gp_mode_in;
  endtask

  function automatic logic [7:0] wbyte(input logic en, input logic spd, input logic nrdy);
    return {en, spd, nrdy, 5'($urandom)};
  endfunction

  // Idle traffic: non-starting writes, other-address writes, pass-through
  task automatic idle_phase(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R8 tx pass", tx_pin, prev_tx);
      chk("R8 mode pass", irmode_pin, prev_gp);
      chk("R11 ready stays", ctrl_rd[0], 1);
      chk("R2 enable rd", ctrl_rd[2], exp_en);
      chk("R2 speed rd", ctrl_rd[1], exp_spd);
      drive_inputs();
      wr_en = 1'b0;
      case ($urandom_range(3))
        0: ;
        1: begin // other address, start pattern: ignored (R2)
          wr_en = 1'b1;
          wr_addr = ADDR_W'($urandom_range(15, 1));
          wr_data = wbyte(1'b1, 1'($urandom), 1'b0);
        end
        2: begin // enable with ready=1: store only (R11)
          wr_en = 1'b1; wr_addr = '0;
          wr_data = wbyte(1'b1, 1'($urandom), 1'b1);
          exp_en = 1'b1; exp_spd = wr_data[6];
        end
        default: begin // enable 0: store only (R11)
          wr_en = 1'b1; wr_addr = '0;
          wr_data = wbyte(1'b0, 1'($urandom), 1'($urandom));
          exp_en = 1'b0; exp_spd = wr_data[6];
        end
      endcase
    end
    @(negedge clk);
    chk("R8 tx pass", tx_pin, prev_tx);
    chk("R8 mode pass", irmode_pin, prev_gp);
    chk("R2 enable rd", ctrl_rd[2], exp_en);
    chk("R2 speed rd", ctrl_rd[1], exp_spd);
    drive_inputs();
    wr_en = 1'b0;
  endtask

  // One programming cycle; abort_at / ign_at are negedge indices after start
  task automatic run_prog(input logic spd, input int abort_at, input int ign_at);
    int last_busy;
    logic seq_out;
    last_busy = (abort_at < S + H - 1) ? abort_at : S + H - 1;
    @(negedge clk);
    chk("R8 tx pass", tx_pin, prev_tx);
    chk("R8 mode pass", irmode_pin, prev_gp);
    chk("R6 ready idle", ctrl_rd[0], 1);
    drive_inputs();
    wr_en = 1'b1; wr_addr = '0; wr_data = wbyte(1'b1, spd, 1'b0);
    for (int t = 0; t <= S + H + 2; t++) begin
      @(negedge clk);
      seq_out = (t >= 1) && (t <= last_busy + 1);
      chk("R3 ready low / R6 ready back", ctrl_rd[0], (t <= last_busy) ? 0 : 1);
      chk("R9 enable rd", ctrl_rd[2], (t <= abort_at) ? 1 : 0);
      chk("R10 speed kept", ctrl_rd[1], spd);
      if (seq_out) begin
        chk((t <= S) ? "R4 setup mode" : "R5 hold mode", irmode_pin, (t <= S) ? 1 : 0);
        chk("R7 tx driven by speed", tx_pin, spd);
      end else begin
        chk("R6 R9 tx released", tx_pin, prev_tx);
        chk("R6 R9 mode released", irmode_pin, prev_gp);
      end
      drive_inputs();
      wr_en = 1'b0;
      if (t == abort_at) begin
        wr_en = 1'b1; wr_addr = '0; wr_data = wbyte(1'b0, ~spd, 1'($urandom));
      end else if (t == ign_at) begin
        wr_en = 1'b1; wr_addr = '0; wr_data = wbyte(1'b1, ~spd, 1'b0);
      end
    end
    exp_en = (abort_at == NO_AB) ? 1'b1 : 1'b0;
    exp_spd = spd;
  endtask

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl_rd", ctrl_rd, 1);
    chk("R1 reset tx", tx_pin, 0);
    chk("R1 reset mode", irmode_pin, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset ctrl_rd", ctrl_rd, 1);
    drive_inputs();
    idle_phase(40);
    run_prog(1'b1, NO_AB, NO_AB);          // R4 R5 R6 fast
    idle_phase(5);
    run_prog(1'b0, NO_AB, NO_AB);          // slow
    run_prog(1'b1, NO_AB, 3);              // R10 ignored write in setup
    run_prog(1'b0, NO_AB, S + 1);          // R10 ignored write in hold
    run_prog(1'b1, 2, NO_AB);              // R9 abort in setup
    run_prog(1'b0, S + 1, NO_AB);          // R9 abort in hold
    run_prog(1'b1, S + H - 1, 1);          // abort on final edge
    idle_phase(10);
    for (int k = 0; k < 30; k++) begin
      int ab, ig;
      ab = ($urandom_range(1) == 0) ? NO_AB : int'($urandom_range(S + H - 1, 1));
      ig = ($urandom_range(1) == 0) ? NO_AB : int'($urandom_range(S + H - 1, 1));
      if (ig >= ab) ig = NO_AB;
      run_prog(1'($urandom), ab, ig);
      if (k % 5 == 0) idle_phase(8);
    end
    idle_phase(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule